// File: doc/BRIEF.md
# Handshake Register Slice

This block is a single pipeline stage for a point-to-point link in which a transmitter raises a strobe when its payload is valid and a receiver raises an acknowledge when it can take a word. A word crosses a link on any rising clock edge where that link's strobe and acknowledge are both high. The slice sits between an upstream transmitter and a downstream receiver. It breaks every combinational path through itself, because each of its outputs comes straight from a flop. It still passes one word per clock while neither side stalls.

Inside there are two payload registers. The main register feeds the output. The spare register catches the one word that can arrive in the same cycle as a downstream stall is first seen. The upstream acknowledge is low only while the spare register holds a word. The downstream strobe is high while the main register holds a word. Words leave in the order they arrived. The payload width is a parameter.

Top module: `hs_reg_slice`

## Requirements
- R1: A word is taken from upstream on a rising edge where in_stb_i and in_ack_o are both high, and it is handed downstream on a rising edge where out_stb_o and out_ack_i are both high. No other edge moves a word.
- R2: When the slice is empty and takes a word, out_stb_o is high after that same edge. It does not wait for out_ack_i.
- R3: While out_stb_o is high and out_ack_i is low, out_stb_o stays high and out_data_o stays unchanged on the next edge.
- R4: in_ack_o falls only on an edge where in_stb_i was high, that is, only on an edge that took a word in.
- R5: While rst_ni is low, out_stb_o and in_ack_o are low and every held word is discarded. No word from before the reset ever appears at the output afterwards.
- R6: When in_stb_i and out_ack_i stay high, one word passes per clock, and out_stb_o and in_ack_o stay high.
- R7: in_ack_o is low exactly while two words are held, and high otherwise. The only exception is the first cycle after reset is released, when it is low. in_ack_o rises on the first edge after release.
- R8: Words leave in arrival order, with none lost and none duplicated, under any stall pattern on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_data_i | input | DATA_W | Upstream payload |
| in_stb_i | input | 1 | Upstream payload valid |
| in_ack_o | output | 1 | Slice ready to take a word, registered |
| out_data_o | output | DATA_W | Downstream payload, registered |
| out_stb_o | output | 1 | Downstream payload valid, registered |
| out_ack_i | input | 1 | Downstream ready |

## Verification
The bench builds the slice with DATA_W of 16. Each word carries a rising sequence number, so any reordering, loss or duplication shows up as a payload mismatch against the bench's queue model. Strobe and acknowledge patterns are drawn at several stall densities, including both sides permanently ready and the downstream side stalled long enough to fill the spare register. Together these reach every occupancy transition: empty, one word held and two words held. A reset is also applied while two words are held, to show that they are dropped.

// File: rtl/hs_slice_pkg.sv
package hs_slice_pkg;

  typedef enum logic [1:0] {
    OCC_EMPTY = 2'd0,
    OCC_MAIN  = 2'd1,
    OCC_BOTH  = 2'd2
  } occ_e;

  typedef enum logic [1:0] {
    SEL_HOLD  = 2'd0,
    SEL_IN    = 2'd1,
    SEL_SPARE = 2'd2
  } main_sel_e;

endpackage

// File: rtl/hs_slice_ctrl.sv
module hs_slice_ctrl
  import hs_slice_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      in_stb_i,
  input  logic      out_ack_i,
  output main_sel_e main_sel_o,
  output logic      spare_load_o,
  output logic      in_ack_o,
  output logic      out_stb_o
);

  occ_e      occ_q, occ_n;
  logic      ack_q, stb_q;
  logic      in_fire, out_fire;
  main_sel_e sel;
  logic      spare_ld;

  assign in_fire  = in_stb_i & ack_q;
  assign out_fire = stb_q & out_ack_i;

  always_comb begin
    occ_n    = occ_q;
    sel      = SEL_HOLD;
    spare_ld = 1'b0;
    unique case (occ_q)
      OCC_EMPTY: begin
        if (in_fire) begin
          occ_n = OCC_MAIN;
          sel   = SEL_IN;
        end
      end
      OCC_MAIN: begin
        if (out_fire && in_fire) begin
          sel = SEL_IN;
        end else if (out_fire) begin
          occ_n = OCC_EMPTY;
        end else if (in_fire) begin
          occ_n    = OCC_BOTH;
          spare_ld = 1'b1;
        end
      end
      OCC_BOTH: begin
        // ack is low here, so only a drain can happen
        if (out_fire) begin
          occ_n = OCC_MAIN;
          sel   = SEL_SPARE;
        end
      end
      default: occ_n = OCC_EMPTY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= OCC_EMPTY;
      ack_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      occ_q <= occ_n;
      ack_q <= (occ_n != OCC_BOTH);
      stb_q <= (occ_n != OCC_EMPTY);
    end
  end

  assign main_sel_o   = sel;
  assign spare_load_o = spare_ld;
  assign in_ack_o     = ack_q;
  assign out_stb_o    = stb_q;

  p_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb_q && in_stb_i && ack_q) |=> stb_q);

  p_ack_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && !in_stb_i) |=> ack_q);

  p_spare_needs_main_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_q && $past(ack_q)) |-> stb_q);

endmodule

// File: rtl/hs_slice_store.sv
module hs_slice_store
  import hs_slice_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  main_sel_e         main_sel_i,
  input  logic              spare_load_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [DATA_W-1:0] main_o
);

  logic [DATA_W-1:0] main_q, spare_q;

  // payload flops carry no reset; validity lives in the control flops
  always_ff @(posedge clk_i) begin
    unique case (main_sel_i)
      SEL_IN:    main_q <= in_data_i;
      SEL_SPARE: main_q <= spare_q;
      default:   main_q <= main_q;
    endcase
    if (spare_load_i) spare_q <= in_data_i;
  end

  assign main_o = main_q;

endmodule

// File: rtl/hs_reg_slice.sv
module hs_reg_slice
  import hs_slice_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_stb_i,
  output logic              in_ack_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_stb_o,
  input  logic              out_ack_i
);

  main_sel_e main_sel;
  logic      spare_load;

  hs_slice_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_stb_i     (in_stb_i),
    .out_ack_i    (out_ack_i),
    .main_sel_o   (main_sel),
    .spare_load_o (spare_load),
    .in_ack_o     (in_ack_o),
    .out_stb_o    (out_stb_o)
  );

  hs_slice_store #(.DATA_W(DATA_W)) u_store (
    .clk_i        (clk_i),
    .main_sel_i   (main_sel),
    .spare_load_i (spare_load),
    .in_data_i    (in_data_i),
    .main_o       (out_data_o)
  );

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_stb_o && !out_ack_i) |=> (out_stb_o && $stable(out_data_o)));

  p_rate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_stb_o && out_ack_i && in_stb_i && in_ack_o) |=> (out_stb_o && in_ack_o));

endmodule

// File: tb/hs_reg_slice_test.sv
module hs_reg_slice_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_stb = 1'b0;
  logic         in_ack;
  logic [W-1:0] out_data;
  logic         out_stb;
  logic         out_ack = 1'b0;

  always #4 clk = ~clk;

  hs_reg_slice #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_data_i(in_data), .in_stb_i(in_stb), .in_ack_o(in_ack),
    .out_data_o(out_data), .out_stb_o(out_stb), .out_ack_i(out_ack)
  );

  logic [W-1:0] q[$];
  int unsigned checks = 0, fails = 0;
  bit           rdy = 0;
  int           tx_p = 0, rx_p = 0;
  bit           hold_rst = 0;
  logic [W-1:0] next_word = 16'h0100;
  bit           p_stb = 0, p_oack = 0, p_ack_exp = 0, p_dut_ack = 0, p_dut_stb = 0;
  logic [W-1:0] p_data = '0, p_out_data = '0;
  int           p_cnt = 0;
  int           out_fires = 0;
  bit           done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit in_f, out_f, exp_ack, exp_stb;
    @(negedge clk);
    if (!rst_ni) begin
      q.delete();
      rdy = 0;
    end else begin
      in_f  = p_stb && p_ack_exp;
      out_f = (p_cnt > 0) && p_oack;
      if (out_f) begin
        void'(q.pop_front());
        out_fires++;
      end
      if (in_f) q.push_back(p_data);
      rdy = 1;
    end
    exp_ack = rdy && (q.size() < 2);
    exp_stb = (q.size() > 0);

    if (!rst_ni) begin
      chk(out_stb == 1'b0, "R5", "out_stb in reset", out_stb, 0);
      chk(in_ack == 1'b0, "R5", "in_ack in reset", in_ack, 0);
    end else begin
      chk(out_stb == exp_stb, "R1 R2", "out_stb", out_stb, exp_stb);
      chk(in_ack == exp_ack, "R7", "in_ack", in_ack, exp_ack);
      if (exp_stb && out_stb)
        chk(out_data == q[0], "R8", "out_data order", out_data, q[0]);
      if (p_dut_stb && !p_oack && rdy && p_cnt > 0)
        chk(out_stb && out_data == p_out_data, "R3", "held word", out_data, p_out_data);
      if (p_dut_ack && !in_ack && p_cnt >= 0)
        chk(p_stb, "R4", "ack fell without stb", p_stb, 1);
    end

    // receiver: a raised ack stays up until a transfer happens
    if (hold_rst) out_ack = 1'b0;
    else if (!(out_ack && !exp_stb)) out_ack = (($urandom % 100) < rx_p);
    // transmitter: a raised strobe stays up with the same word until taken
    if (hold_rst) in_stb = 1'b0;
    else if (!(in_stb && !exp_ack)) begin
      in_stb = (($urandom % 100) < tx_p);
      if (in_stb) begin
        in_data = next_word;
        next_word = next_word + 1'b1;
      end
    end

    p_stb = in_stb; p_data = in_data; p_oack = out_ack;
    p_ack_exp = exp_ack; p_cnt = q.size();
    p_dut_ack = in_ack; p_dut_stb = out_stb; p_out_data = out_data;
  endtask

  initial begin
    int base;
    hold_rst = 1;
    repeat (3) step();
    rst_ni = 1'b1;
    hold_rst = 0;

    // R6: both sides always ready
    tx_p = 100; rx_p = 100;
    repeat (20) step();
    base = out_fires;
    repeat (40) step();
    chk(out_fires - base == 40, "R6", "words in 40 cycles", out_fires - base, 40);
    chk(in_ack && out_stb, "R6", "both high while streaming", {in_ack, out_stb}, 2'b11);

    // random stalls on both sides
    tx_p = 50; rx_p = 50;
    repeat (1500) step();
    tx_p = 90; rx_p = 30;
    repeat (800) step();
    tx_p = 30; rx_p = 90;
    repeat (800) step();

    // R7: fill with downstream stalled
    tx_p = 100; rx_p = 0;
    repeat (12) step();
    chk(in_ack == 1'b0, "R7", "ack low with two held", in_ack, 0);
    chk(out_stb == 1'b1, "R7", "stb high with two held", out_stb, 1);

    // R5: reset while full, then stream again
    hold_rst = 1;
    rst_ni = 1'b0;
    repeat (4) step();
    rst_ni = 1'b1;
    hold_rst = 0;
    step();
    chk(in_ack == 1'b1, "R7", "ack up one edge after release", in_ack, 1);
    chk(out_stb == 1'b0, "R5", "old words dropped", out_stb, 0);
    tx_p = 60; rx_p = 60;
    repeat (600) step();
    tx_p = 0; rx_p = 100;
    repeat (10) step();
    chk(out_stb == 1'b0, "R8", "drained empty", out_stb, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule